// File: doc/BRIEF.md
# Multiplexed Grid/Segment Display Scanner

This block refreshes a time-multiplexed LED display from a 14-byte display memory. It lights one grid (digit) at a time, starting at grid 1 and climbing to the last grid the mode allows before returning to grid 1. For each grid it reads that digit's two memory bytes through a combinational read port. It then drives the grid line and the digit's segment lines for a fixed time slot. Brightness is one of eight duty steps.

A 2-bit mode input trades segment lines for grid lines, because the top three segment pins double as grids 5 to 7 on the board. The block also has a display enable and a 3-bit dimming step input. All outputs are active high. Bit i of `segOut` is segment i+1, and bit i of `gridOut` is grid i+1. Each slot lasts 16 phases of `TICK_DIV` clock cycles. Phase 0 is a blank guard phase in which the digit's bytes are fetched.

Top module: `led_scan_top`

## Requirements
- R1: The mode input selects the layout: 00 gives 4 grids and 12 segments, 01 gives 5 and 11, 10 gives 6 and 10, 11 gives 7 and 9.
- R2: During reset all grid and segment outputs are inactive. Reset selects the 7-grid, 9-segment layout, so with mode held at 11 and enable high the display runs without any further action.
- R3: At most one grid is active at any time. Grids are visited in ascending order from grid 1 to the last active grid, then back to grid 1.
- R4: Digit n (n = 1..7) reads memory addresses 2(n-1) and 2(n-1)+1. Bits 7:0 of the even byte drive segments 1 to 8, and bits 3:0 of the odd byte drive segments 9 to 12. `memAddr` never exceeds 13.
- R5: Each grid's slot lasts 16·TICK_DIV cycles. The grid is active for 15·TICK_DIV of them. At least one fully blank cycle separates two different active grids.
- R6: Within a slot, a lit segment is active for (dim+1)·TICK_DIV cycles, where dim is 0 to 7. No segment is ever active while no grid is active.
- R7: Segments and grids beyond the counts of the current mode stay inactive, whatever the memory holds. Segment pins 10, 11 and 12 are never active together with grids 7, 6 and 5 respectively.
- R8: While enable is low, all outputs are inactive, but scanning and memory reads go on.
- R9: A change of the mode input blanks all outputs from the second cycle after the change. The outputs stay blank until enable is taken low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Grid/segment layout select |
| dispEn | input | 1 | Display enable; a rising edge clears a mode-change blank |
| dim | input | 3 | Brightness step, duty (dim+1)/16 |
| memAddr | output | 4 | Display memory read address |
| memData | input | 8 | Display memory read data, same cycle as address |
| segOut | output | 12 | Segment drives, bit i = segment i+1, active high |
| gridOut | output | 7 | Grid drives, bit i = grid i+1, active high |

## Verification
The main function is tried with a table of layouts and brightness steps, each with its own memory image. Every per-grid and per-segment on-time is measured over a window of exactly one frame, which makes the result independent of scan phase. An all-ones image at the default layout shows that the top odd-byte bits are dropped when only nine segments are in use. Scrambled images in each mode tell a correct even/odd byte mapping apart from swapped or shifted bytes. Dim values 0 and 7 separate a correct duty from an off-by-one phase compare. Directed tests then separate "disabled but scanning" from "stopped", and a blank that holds until the enable is re-armed from one that clears by itself.

// File: rtl/led_scan_pkg.sv
`timescale 1ns/1ps
package led_scan_pkg;
  localparam int SEG_N     = 12;
  localparam int GRID_N    = 7;
  localparam int MIN_GRIDS = 4;
  localparam int BYTE_W    = 8;
  localparam int HI_W      = SEG_N - BYTE_W;
  localparam int MODE_W    = 2;
  localparam int DIM_W     = 3;
  localparam int PHASE_N   = 16;
  localparam int PHASE_W   = $clog2(PHASE_N);
  localparam int GIDX_W    = $clog2(GRID_N);
  localparam int MEM_DEPTH = 2 * GRID_N;
  localparam int MEM_AW    = $clog2(MEM_DEPTH);

  typedef struct packed {
    logic fetchEven;
    logic fetchOdd;
    logic addrLsb;
    logic gridOn;
    logic segOn;
  } scanStrobe_t;

  function automatic logic [SEG_N-1:0] segMaskOf(input logic [MODE_W-1:0] m);
    return {SEG_N{1'b1}} >> m;
  endfunction

  function automatic logic [GRID_N-1:0] gridMaskOf(input logic [MODE_W-1:0] m);
    return {GRID_N{1'b1}} >> (MODE_W'(3) - m);
  endfunction
endpackage

// File: rtl/led_scan_ctrl.sv
`timescale 1ns/1ps
module led_scan_ctrl
  import led_scan_pkg::*;
#(
  parameter int TICK_DIV = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [MODE_W-1:0]   mode,
  input  logic                dispEn,
  input  logic [DIM_W-1:0]    dim,
  output scanStrobe_t         strb,
  output logic [GIDX_W-1:0]   gridIdx,
  output logic [MODE_W-1:0]   modeReg
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PRE_W-1:0]   preCnt;
  logic [PHASE_W-1:0] phase;
  logic               blanked;
  logic               enPrev;
  logic               modeChg;
  logic               preWrap;
  logic               phaseWrap;
  logic [GIDX_W-1:0]  lastGrid;
  logic               lit;

  assign modeChg   = (mode != modeReg);
  assign preWrap   = (preCnt == PRE_W'(TICK_DIV - 1));
  assign phaseWrap = (phase == PHASE_W'(PHASE_N - 1));
  assign lastGrid  = GIDX_W'(MIN_GRIDS - 1) + GIDX_W'(modeReg);
  assign lit       = dispEn && !blanked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '1;
      blanked <= 1'b0;
      enPrev  <= 1'b0;
      preCnt  <= '0;
      phase   <= '0;
      gridIdx <= '0;
    end else begin
      enPrev <= dispEn;
      if (modeChg) begin
        modeReg <= mode;
        blanked <= 1'b1;
        preCnt  <= '0;
        phase   <= '0;
        gridIdx <= '0;
      end else begin
        if (dispEn && !enPrev) blanked <= 1'b0;
        if (preWrap) begin
          preCnt <= '0;
          if (phaseWrap) begin
            phase   <= '0;
            gridIdx <= (gridIdx == lastGrid) ? '0 : gridIdx + 1'b1;
          end else begin
            phase <= phase + 1'b1;
          end
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.fetchEven = (phase == '0) && (preCnt == '0);
    strb.fetchOdd  = (phase == '0) && (preCnt == PRE_W'(1));
    strb.addrLsb   = (preCnt != '0);
    strb.gridOn    = lit && (phase != '0);
    strb.segOn     = lit && (phase != '0) && (phase <= PHASE_W'(dim) + PHASE_W'(1));
  end
endmodule

// File: rtl/led_scan_dp.sv
`timescale 1ns/1ps
module led_scan_dp
  import led_scan_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  scanStrobe_t        strb,
  input  logic [GIDX_W-1:0]  gridIdx,
  input  logic [MODE_W-1:0]  modeReg,
  output logic [MEM_AW-1:0]  memAddr,
  input  logic [BYTE_W-1:0]  memData,
  output logic [SEG_N-1:0]   segOut,
  output logic [GRID_N-1:0]  gridOut
);
  logic [BYTE_W-1:0] loByte;
  logic [HI_W-1:0]   hiNib;

  assign memAddr = {gridIdx, strb.addrLsb};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loByte  <= '0;
      hiNib   <= '0;
      segOut  <= '0;
      gridOut <= '0;
    end else begin
      if (strb.fetchEven) loByte <= memData;
      if (strb.fetchOdd)  hiNib  <= memData[HI_W-1:0];
      gridOut <= strb.gridOn ? (GRID_N'(1) << gridIdx) : '0;
      segOut  <= strb.segOn ? ({hiNib, loByte} & segMaskOf(modeReg)) : '0;
    end
  end
endmodule

// File: rtl/led_scan_top.sv
`timescale 1ns/1ps
module led_scan_top
  import led_scan_pkg::*;
#(
  parameter int TICK_DIV = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         mode,
  input  logic               dispEn,
  input  logic [2:0]         dim,
  output logic [3:0]         memAddr,
  input  logic [7:0]         memData,
  output logic [11:0]        segOut,
  output logic [6:0]         gridOut
);
  scanStrobe_t       strb;
  logic [GIDX_W-1:0] gridIdx;
  logic [MODE_W-1:0] modeReg;

  led_scan_ctrl #(.TICK_DIV(TICK_DIV)) ctrl_i (
    .clk(clk), .rstN(rstN), .mode(mode), .dispEn(dispEn), .dim(dim),
    .strb(strb), .gridIdx(gridIdx), .modeReg(modeReg)
  );

  led_scan_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .gridIdx(gridIdx), .modeReg(modeReg),
    .memAddr(memAddr), .memData(memData), .segOut(segOut), .gridOut(gridOut)
  );
endmodule

// File: rtl/led_scan_chk.sv
`timescale 1ns/1ps
module led_scan_chk
  import led_scan_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  mode,
  input logic        dispEn,
  input logic [3:0]  memAddr,
  input logic [11:0] segOut,
  input logic [6:0]  gridOut
);
  p_grid_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gridOut));

  p_addr_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    memAddr < 4'(MEM_DEPTH));

  p_seg_needs_grid_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|segOut) |-> (|gridOut));

  p_unused_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mode) == mode && $past(mode, 2) == mode) |->
      ((gridOut & ~gridMaskOf(mode)) == '0 && (segOut & ~segMaskOf(mode)) == '0));

  p_shared_pins_r7: assert property (@(posedge clk) disable iff (!rstN)
    ({segOut[11], segOut[10], segOut[9]} & {gridOut[4], gridOut[5], gridOut[6]}) == 3'b000);

  p_disabled_dark_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(dispEn) |-> (gridOut == '0 && segOut == '0));

  p_mode_blank_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mode, 2) != $past(mode, 3)) |-> (gridOut == '0 && segOut == '0));
endmodule

bind led_scan_top led_scan_chk chk_i (
  .clk(clk), .rstN(rstN), .mode(mode), .dispEn(dispEn),
  .memAddr(memAddr), .segOut(segOut), .gridOut(gridOut)
);

// File: tb/led_scan_top_tb_top.sv
`timescale 1ns/1ps
module led_scan_top_tb_top;
  localparam int TD   = 2;
  localparam int SLOT = 16 * TD;
  localparam int NVEC = 6;
  // vector: {mode[1:0], dim[2:0], seed[7:0]}; seed FF means all-ones memory
  localparam logic [12:0] VEC [NVEC] = '{
    {2'b11, 3'd7, 8'hFF},
    {2'b00, 3'd0, 8'h5A},
    {2'b01, 3'd3, 8'hC3},
    {2'b10, 3'd5, 8'h96},
    {2'b11, 3'd1, 8'h3C},
    {2'b00, 3'd6, 8'hA5}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  mode = 2'b11;
  logic        dispEn = 1'b1;
  logic [2:0]  dim = 3'd7;
  logic [3:0]  memAddr;
  logic [7:0]  memData;
  logic [11:0] segOut;
  logic [6:0]  gridOut;

  logic [7:0] mem [14];
  int errors = 0;
  int checks = 0;
  int gCnt [7];
  int sCnt [7][12];
  int orderBad, stray, totalOn;
  logic [13:0] addrSeen;

  always #2.5 clk = ~clk;

  assign memData = (memAddr < 4'd14) ? mem[memAddr] : 8'h00;

  led_scan_top #(.TICK_DIV(TD)) dut_i (
    .clk(clk), .rstN(rstN), .mode(mode), .dispEn(dispEn), .dim(dim),
    .memAddr(memAddr), .memData(memData), .segOut(segOut), .gridOut(gridOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fillMem(input logic [7:0] seed);
    for (int a = 0; a < 14; a++)
      mem[a] = (seed == 8'hFF) ? 8'hFF : (seed ^ 8'(a * 29));
  endtask

  task automatic measure(input int nG);
    int lastG = -1;
    int prevG = -1;
    orderBad = 0; stray = 0; totalOn = 0; addrSeen = '0;
    for (int g = 0; g < 7; g++) begin
      gCnt[g] = 0;
      for (int s = 0; s < 12; s++) sCnt[g][s] = 0;
    end
    repeat (nG * SLOT) begin
      int cur = -1;
      @(negedge clk);
      for (int g = 0; g < 7; g++) if (gridOut[g]) cur = g;
      totalOn += $countones(gridOut) + $countones(segOut);
      if (cur >= 0) begin
        gCnt[cur]++;
        for (int s = 0; s < 12; s++) if (segOut[s]) sCnt[cur][s]++;
        if (lastG >= 0 && cur != lastG && cur != (lastG + 1) % nG) orderBad++;
        if (prevG >= 0 && cur != prevG) orderBad++;
        lastG = cur;
      end else begin
        stray += $countones(segOut);
      end
      prevG = cur;
      addrSeen[memAddr] = 1'b1;
    end
  endtask

  task automatic compareFrame(input logic [1:0] m, input logic [2:0] d);
    int nG = 4 + int'(m);
    int nS = 12 - int'(m);
    for (int g = 0; g < 7; g++) begin
      int expG = (g < nG) ? 15 * TD : 0;
      int badS = -1;
      int actS = 0;
      int expS = 0;
      check(gCnt[g] == expG, "R1 R5 grid on-time", gCnt[g], expG);
      for (int s = 0; s < 12; s++) begin
        bit b = (s < 8) ? mem[2*g][s] : mem[2*g+1][s-8];
        int e = (g < nG && s < nS && b) ? (int'(d) + 1) * TD : 0;
        if (sCnt[g][s] != e && badS < 0) begin badS = s; actS = sCnt[g][s]; expS = e; end
      end
      // R4 mapping, R6 duty, R7 unused segments ignored
      check(badS < 0, "R4 R6 R7 segment on-time", actS, expS);
    end
    check(orderBad == 0, "R3 R5 scan order and guard", orderBad, 0);
    check(stray == 0, "R6 segment without grid", stray, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    fillMem(8'hFF);
    // R2: reset state
    repeat (4) @(negedge clk);
    check(gridOut == '0, "R2 reset grids", int'(gridOut), 0);
    check(segOut == '0, "R2 reset segments", int'(segOut), 0);
    @(negedge clk) rstN = 1'b1;
    // R2: default layout runs with mode 11, no enable toggle
    repeat (2 * 7 * SLOT) @(negedge clk);
    measure(7);
    compareFrame(2'b11, 3'd7);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] m = VEC[v][12:11];
      logic [2:0] d = VEC[v][10:8];
      @(negedge clk);
      dispEn = 1'b0; mode = m; dim = d;
      fillMem(VEC[v][7:0]);
      repeat (2) @(negedge clk);
      dispEn = 1'b1;
      repeat (2 * (4 + int'(m)) * SLOT) @(negedge clk);
      measure(4 + int'(m));
      compareFrame(m, d);
    end

    // R8: disabled while scanning continues
    @(negedge clk);
    mode = 2'b10; dim = 3'd4; fillMem(8'h71); dispEn = 1'b0;
    repeat (2 * 6 * SLOT) @(negedge clk);
    measure(6);
    check(totalOn == 0, "R8 disabled outputs dark", totalOn, 0);
    check($countones(addrSeen) == 12, "R8 reads continue while disabled", $countones(addrSeen), 12);
    dispEn = 1'b1;
    repeat (6 * SLOT) @(negedge clk);
    measure(6);
    compareFrame(2'b10, 3'd4);

    // R9: mode change blanks until enable re-armed
    @(negedge clk) mode = 2'b01;
    repeat (3) @(negedge clk);
    measure(5);
    check(totalOn == 0, "R9 blank after mode change", totalOn, 0);
    measure(5);
    check(totalOn == 0, "R9 blank persists with enable high", totalOn, 0);
    dispEn = 1'b0;
    repeat (2) @(negedge clk);
    dispEn = 1'b1;
    repeat (5 * SLOT) @(negedge clk);
    measure(5);
    compareFrame(2'b01, 3'd4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule